// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block supervises software by counting down in a clock domain of its own, apart from the bus clock. If software fails to refresh it in time, it raises a system reset request. Software reaches it only through register writes on a small bus port. Three magic codes written to the key register do the control work. One code arms the watchdog. One refresh code copies the reload value into the down-counter. One code opens the prescaler and reload registers for writing. Those two registers refuse writes at all other times.

Each bus write is held in the bus domain and handed across with a toggle handshake, which is synchronised into the watchdog clock. A busy flag stays high until the watchdog side has applied the write. A write offered while the flag is high is dropped. The down-counter advances once every 4·2^P watchdog cycles, where P is the prescaler setting. When the counter runs out, the block emits a fixed-length reset pulse and returns to the stopped state.

Top module: `iwdt_top`

## Requirements
- R1: Writing 0xCCCC to the key register (address 0) while the watchdog is stopped and no reset pulse is active starts it. The counter begins at 0xFFF, so with the reset-default settings the reset request rises 4095·4 watchdog cycles after the start.
- R2: Writing 0xAAAA to the key register while running loads the reload value into the counter and restarts the prescale phase. Refreshes that come more often than the timeout keep the reset request low.
- R3: A write to the prescaler register (address 1, setting in data bits 2:0) or the reload register (address 2, value in data bits 11:0) takes effect only while the unlock state is set. Writing 0x5555 to the key register sets it. Otherwise the write is ignored.
- R4: Any key write other than 0x5555 clears the unlock state. Writes to the prescaler and reload registers do not clear it.
- R5: The counter steps once every 4·2^min(P,6) watchdog cycles. A prescaler setting of 7 acts as 6 (divide by 256). After a refresh, the reset request rises reload·divider cycles later.
- R6: Once running, the watchdog is not stopped by any key write. Only its own timeout or the watchdog-domain reset stops it.
- R7: The reset request is a single pulse of exactly 4 watchdog cycles. During the pulse and after it, the running flag is low, and a start code is not accepted while the pulse lasts.
- R8: The busy output rises in the bus cycle after a write is accepted. It falls only after the watchdog side has applied that write. A write presented while busy is high is discarded.
- R9: After reset, the watchdog is stopped, busy and the reset request are low, the prescaler is 0 and the reload value is 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus-domain reset, active low |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select: 0 key, 1 prescaler, 2 reload |
| bus_wdata | input | 16 | Write data |
| bus_busy | output | 1 | High while a write is crossing into the watchdog domain |
| wdg_clk | input | 1 | Independent watchdog clock |
| wdg_rst_n | input | 1 | Watchdog-domain reset, active low |
| wdg_running | output | 1 | Watchdog is counting |
| wdg_rst_req | output | 1 | System reset request pulse |

## Verification
The in-line assertions are evaluated on every cycle. They cover four properties. The running flag only falls when a reset pulse begins. Running and the pulse never overlap. The reload register only changes in the cycle after the unlock state was set. Captured write data stays frozen while a crossing is pending. The timeout lengths, the prescaler saturation, the keep-alive behaviour of refreshes, the dropping of writes while busy and the exact pulse width depend on whole sequences of writes across two unrelated clocks. The bench's directed scenarios measure these in watchdog cycles, with a small tolerance for synchroniser latency.

// File: rtl/iwdt_pkg.sv
`timescale 1ns/1ps
package iwdt_pkg;
    localparam int KEY_W  = 16;
    localparam int ADDR_W = 2;

    typedef logic [KEY_W-1:0]  key_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t A_KEY = 2'd0;
    localparam addr_t A_PRE = 2'd1;
    localparam addr_t A_RLD = 2'd2;

    localparam key_t K_START   = 16'hCCCC;
    localparam key_t K_REFRESH = 16'hAAAA;
    localparam key_t K_UNLOCK  = 16'h5555;
endpackage

// File: rtl/iwdt_bus_port.sv
`timescale 1ns/1ps
module iwdt_bus_port
    import iwdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we_i,
    input  addr_t addr_i,
    input  key_t  data_i,
    input  logic  ack_tog_i,
    output logic  req_tog_o,
    output addr_t cmd_addr_o,
    output key_t  cmd_data_o,
    output logic  busy_o
);
    typedef struct packed {
        logic  tog;
        addr_t addr;
        key_t  data;
        logic  ack_s1;
        logic  ack_s2;
    } port_t;

    port_t q, d;
    logic  busy;

    assign busy = q.tog != q.ack_s2;

    always_comb begin
        d        = q;
        d.ack_s1 = ack_tog_i;
        d.ack_s2 = q.ack_s1;
        if (we_i && !busy) begin
            d.tog  = ~q.tog;
            d.addr = addr_i;
            d.data = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_tog_o  = q.tog;
    assign cmd_addr_o = q.addr;
    assign cmd_data_o = q.data;
    assign busy_o     = busy;

    AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_o) |-> ($stable(cmd_data_o) && $stable(cmd_addr_o))); // R8
endmodule

// File: rtl/iwdt_cmd_sync.sv
`timescale 1ns/1ps
module iwdt_cmd_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic req_tog_i,
    output logic cmd_valid_o,
    output logic ack_tog_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.s1 = req_tog_i;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_valid_o = q.s2 ^ q.s3;
    assign ack_tog_o   = q.s3;
endmodule

// File: rtl/iwdt_core.sv
`timescale 1ns/1ps
module iwdt_core
    import iwdt_pkg::*;
#(
    parameter int RLD_W     = 12,
    parameter int PR_W      = 3,
    parameter int PR_MAX    = 6,
    parameter int BASE_LOG  = 2,
    parameter int PULSE_LEN = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cmd_valid_i,
    input  addr_t cmd_addr_i,
    input  key_t  cmd_data_i,
    output logic  running_o,
    output logic  rst_req_o
);
    localparam int PC_W = BASE_LOG + PR_MAX;
    localparam int PL_W = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic             running;
        logic             unlock;
        logic [PR_W-1:0]  pr;
        logic [RLD_W-1:0] rld;
        logic [RLD_W-1:0] cnt;
        logic [PC_W-1:0]  pcnt;
        logic [PL_W-1:0]  pls;
    } core_t;

    core_t q, d;
    logic  tick, fire;
    logic [PC_W-1:0] term;

    always_comb begin
        term = '0;
        for (int i = 0; i <= PR_MAX; i++) begin
            if (int'(q.pr) == i || (i == PR_MAX && int'(q.pr) > PR_MAX))
                term = PC_W'((1 << (BASE_LOG + i)) - 1);
        end
    end

    always_comb begin
        d    = q;
        tick = 1'b0;
        fire = 1'b0;
        if (q.pls != '0) d.pls = q.pls - 1'b1;
        if (q.running) begin
            if (q.pcnt >= term) begin
                d.pcnt = '0;
                tick   = 1'b1;
            end else begin
                d.pcnt = q.pcnt + 1'b1;
            end
            if (tick) begin
                if (q.cnt <= RLD_W'(1)) begin
                    fire      = 1'b1;
                    d.running = 1'b0;
                    d.cnt     = '0;
                    d.pls     = PL_W'(PULSE_LEN);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
        end
        if (cmd_valid_i) begin
            case (cmd_addr_i)
                A_KEY: begin
                    d.unlock = (cmd_data_i == K_UNLOCK);
                    if (cmd_data_i == K_START && !q.running && q.pls == '0) begin
                        d.running = 1'b1;
                        d.cnt     = '1;
                        d.pcnt    = '0;
                    end
                    if (cmd_data_i == K_REFRESH && q.running && !fire) begin
                        d.cnt  = q.rld;
                        d.pcnt = '0;
                    end
                end
                A_PRE: if (q.unlock) d.pr  = cmd_data_i[PR_W-1:0];
                A_RLD: if (q.unlock) d.rld = cmd_data_i[RLD_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.rld <= '1;
        end else begin
            q <= d;
        end
    end

    assign running_o = q.running;
    assign rst_req_o = q.pls != '0;

    AST_STOP_ONLY_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running_o) |-> rst_req_o); // R6
    AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> !running_o); // R7
    AST_RLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.rld) |-> $past(q.unlock)); // R3
    AST_PR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.pr) |-> $past(q.unlock)); // R3
endmodule

// File: rtl/iwdt_top.sv
`timescale 1ns/1ps
module iwdt_top
    import iwdt_pkg::*;
#(
    parameter int RLD_W     = 12,
    parameter int PR_W      = 3,
    parameter int PR_MAX    = 6,
    parameter int BASE_LOG  = 2,
    parameter int PULSE_LEN = 4
) (
    input  logic        bus_clk,
    input  logic        bus_rst_n,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic        bus_busy,
    input  logic        wdg_clk,
    input  logic        wdg_rst_n,
    output logic        wdg_running,
    output logic        wdg_rst_req
);
    logic  req_tog, ack_tog, cmd_valid;
    addr_t cmd_addr;
    key_t  cmd_data;

    iwdt_bus_port u_port (
        .clk        (bus_clk),
        .rst_n      (bus_rst_n),
        .we_i       (bus_we),
        .addr_i     (bus_addr),
        .data_i     (bus_wdata),
        .ack_tog_i  (ack_tog),
        .req_tog_o  (req_tog),
        .cmd_addr_o (cmd_addr),
        .cmd_data_o (cmd_data),
        .busy_o     (bus_busy)
    );

    iwdt_cmd_sync u_sync (
        .clk         (wdg_clk),
        .rst_n       (wdg_rst_n),
        .req_tog_i   (req_tog),
        .cmd_valid_o (cmd_valid),
        .ack_tog_o   (ack_tog)
    );

    iwdt_core #(
        .RLD_W     (RLD_W),
        .PR_W      (PR_W),
        .PR_MAX    (PR_MAX),
        .BASE_LOG  (BASE_LOG),
        .PULSE_LEN (PULSE_LEN)
    ) u_core (
        .clk         (wdg_clk),
        .rst_n       (wdg_rst_n),
        .cmd_valid_i (cmd_valid),
        .cmd_addr_i  (cmd_addr),
        .cmd_data_i  (cmd_data),
        .running_o   (wdg_running),
        .rst_req_o   (wdg_rst_req)
    );
endmodule

// File: tb/sim_iwdt_top.sv
`timescale 1ns/1ps
module sim_iwdt_top;
    logic        bus_clk = 1'b0;
    logic        wdg_clk = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        wdg_rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_busy, wdg_running, wdg_rst_req;

    int checks = 0;
    int failures = 0;
    int rst_rises = 0;
    logic rst_prev = 1'b0;

    always #5  bus_clk = ~bus_clk;
    always #13 wdg_clk = ~wdg_clk;

    iwdt_top u0 (
        .bus_clk     (bus_clk),
        .bus_rst_n   (bus_rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_busy    (bus_busy),
        .wdg_clk     (wdg_clk),
        .wdg_rst_n   (wdg_rst_n),
        .wdg_running (wdg_running),
        .wdg_rst_req (wdg_rst_req)
    );

    always @(posedge wdg_clk) begin
        if (wdg_rst_req && !rst_prev) rst_rises <= rst_rises + 1;
        rst_prev <= wdg_rst_req;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] v);
        @(negedge bus_clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge bus_clk);
        bus_we = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        int n = 0;
        bus_write(a, v);
        while (bus_busy && n < 200) begin @(negedge bus_clk); n++; end
    endtask

    function automatic int divider(input int pr);
        return 4 << ((pr > 6) ? 6 : pr);
    endfunction

    task automatic expire(input logic [15:0] key, input int exp_cyc, input string tag);
        int n = 0;
        int w = 0;
        bus_write(2'd0, key);
        while (!wdg_rst_req && n < exp_cyc + 50) begin @(negedge wdg_clk); n++; end
        check(n >= exp_cyc + 1 && n <= exp_cyc + 5, tag, n, exp_cyc);
        while (wdg_rst_req && w < 20) begin w++; @(negedge wdg_clk); end
        check(w == 4, "R7 pulse width", w, 4);
        check(!wdg_running, "R7 idle after pulse", int'(wdg_running), 0);
        repeat (4) @(negedge bus_clk);
    endtask

    task automatic t_reset();
        check(!wdg_running, "R9 running after reset", int'(wdg_running), 0);
        check(!bus_busy, "R9 busy after reset", int'(bus_busy), 0);
        check(!wdg_rst_req, "R9 rst_req after reset", int'(wdg_rst_req), 0);
    endtask

    task automatic t_default_timeout();
        expire(16'hCCCC, 4095 * 4, "R1 default timeout from start");
    endtask

    task automatic t_busy_drop();
        bus_write(2'd0, 16'h1234);
        check(bus_busy, "R8 busy after write", int'(bus_busy), 1);
        bus_write(2'd0, 16'hCCCC);
        wr(2'd0, 16'h0000);
        check(!bus_busy, "R8 busy clears", int'(bus_busy), 0);
        check(!wdg_running, "R8 write while busy dropped", int'(wdg_running), 0);
    endtask

    task automatic t_config();
        wr(2'd0, 16'hCCCC);
        check(wdg_running, "R1 start sets running", int'(wdg_running), 1);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'h0001);
        wr(2'd2, 16'd10);
        expire(16'hAAAA, 10 * divider(1), "R5 R3 timeout pr=1 rld=10");
    endtask

    task automatic t_relock();
        wr(2'd0, 16'hCCCC);
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'd3);
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h1234);
        wr(2'd2, 16'd100);
        wr(2'd1, 16'h0005);
        expire(16'hAAAA, 3 * divider(0), "R4 relock keeps rld=3 pr=0");
    endtask

    task automatic t_saturate();
        wr(2'd0, 16'hCCCC);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'h0007);
        wr(2'd2, 16'd2);
        expire(16'hAAAA, 2 * 256, "R5 pr=7 saturates to 256");
    endtask

    task automatic t_keepalive();
        int r0;
        wr(2'd0, 16'hCCCC);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'd10);
        r0 = rst_rises;
        for (int i = 0; i < 12; i++) begin
            wr(2'd0, 16'hAAAA);
            repeat (6) @(negedge bus_clk);
        end
        check(rst_rises == r0, "R2 refresh keeps reset low", rst_rises - r0, 0);
        check(wdg_running, "R2 still running", int'(wdg_running), 1);
        expire(16'hAAAA, 10 * divider(0), "R2 refresh reloads rld=10");
    endtask

    task automatic t_nostop();
        int r0;
        wr(2'd0, 16'hCCCC);
        r0 = rst_rises;
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'h1234);
        wr(2'd0, 16'hCCCC);
        wr(2'd0, 16'hFFFF);
        check(wdg_running, "R6 key writes do not stop", int'(wdg_running), 1);
        check(rst_rises == r0, "R6 no reset from key writes", rst_rises - r0, 0);
        expire(16'hAAAA, 10 * divider(0), "R6 still times out");
    endtask

    initial begin
        repeat (5) @(negedge bus_clk);
        bus_rst_n = 1'b1;
        wdg_rst_n = 1'b1;
        repeat (5) @(negedge bus_clk);
        t_reset();
        t_default_timeout();
        t_busy_drop();
        t_config();
        t_relock();
        t_saturate();
        t_keepalive();
        t_nostop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1500000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule